// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a single-port synchronous memory with a 32-bit word split into four byte lanes, fronted by the control decode of a pipelined burst cache RAM. A cycle starts when one of two address-status strobes is low. The processor-side strobe counts only while chip enable is low. The controller-side strobe always counts. The address is loaded into a two-bit burst sequencer, and later cycles either advance the burst or hold it. Writes use the write data presented on the same clock edge as the write controls of that beat. Read data is registered and appears one clock after the beat is accepted.

The device answers only when the enable and both selects are in their active state. A cycle started while unselected deselects the device, and the read drive falls after that one clock. Instead of a tristate pad, the output is a data word plus a drive-enable. The drive-enable is forced low by an asynchronous output-enable input and by any write in the current cycle. It is also held off for one cycle when the device is selected again right after a deselect cycle, which avoids bus contention when two banks share the bus. A sleep input freezes all state and keeps the memory contents.

Top module: `burst_sram_ctrl`

## Requirements
- R1: The device is selected only when ce_ni=0, cs0_i=1 and cs1_ni=0. A cycle started while not selected is a deselect cycle, and rdata_oe_o is 0 from the next clock until a selected read has produced data.
- R2: The data of a read beat accepted on clock edge k is on rdata_o after edge k, with rdata_oe_o=1 (unless R9, R10 or R11 applies).
- R3: With linear_i=1, the two low address bits of beat n (n=0..3) are (start + n) mod 4. The upper bits stay fixed, and the sequence wraps after four beats.
- R4: With linear_i=0, the two low address bits of beat n are start XOR n.
- R5: A beat with adv_ni=1 inside a burst repeats the address of the previous beat.
- R6: gw_ni=0 on a beat writes all four lanes, whatever bwe_ni and bw_ni are.
- R7: With gw_ni=1 and bwe_ni=0, lane n (data bits 8n+7..8n) is written when bw_ni[n]=0, and several lanes may be written together. With gw_ni=1 and bwe_ni=1 the beat is a read.
- R8: A cycle started with adsp_ni=0 and ce_ni=0 writes nothing and is a read. adsp_ni is ignored while ce_ni=1, so the burst in progress continues, including its writes.
- R9: In a cycle that writes, rdata_oe_o is 0. A later read of that address returns the written data.
- R10: A selected start directly after a deselect cycle keeps rdata_oe_o at 0 for the first cycle after that start. From the next cycle the drive follows R2.
- R11: oe_ni=1 forces rdata_oe_o to 0 in the same cycle.
- R12: While sleep_i=1 no state changes: no write, no load, no advance, and rdata_o is stable. Memory contents are retained.
- R13: After reset rdata_o=0 and rdata_oe_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_i | input | 1 | Freeze all state (clock enable low) |
| ce_ni | input | 1 | Chip enable, active low; also gates adsp_ni |
| cs0_i | input | 1 | Chip select, active high |
| cs1_ni | input | 1 | Chip select, active low |
| adsp_ni | input | 1 | Processor-side start strobe, active low, read-only |
| adsc_ni | input | 1 | Controller-side start strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| gw_ni | input | 1 | Global write, all lanes, active low |
| bwe_ni | input | 1 | Byte-write gate, active low |
| bw_ni | input | 4 | Per-lane write strobes, active low |
| linear_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| addr_i | input | ADDR_W | Word address, loaded on a start |
| wdata_i | input | 32 | Write data for the current beat |
| rdata_o | output | 32 | Registered read data |
| rdata_oe_o | output | 1 | Read data drive enable |

## Verification
Writes land on the edge that ends their beat, and read data follows one edge later. The bench drives each beat's inputs after a falling edge and compares both outputs 1 ns later. At that point rdata_o shows the beat before, and rdata_oe_o already reflects this cycle's write, oe_ni and bank-switch hold. A behavioural model commits its state on the rising edge and predicts every cycle. Literal checks after selected beats pin down the burst orders, lane merges, the blocked write and the one-cycle drive hold after a bank switch.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  typedef enum logic {
    ORD_INTERLEAVED = 1'b0,
    ORD_LINEAR      = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              linear_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] beat_addr_o
);
  logic [ADDR_W-1:0]  base_q, base_d;
  logic [BURST_W-1:0] cnt_q, cnt_d, low;

  always_comb begin
    base_d = load_i ? addr_i : base_q;
    if (load_i)     cnt_d = '0;
    else if (adv_i) cnt_d = cnt_q + 1'b1;
    else            cnt_d = cnt_q;
    if (burst_order_e'(linear_i) == ORD_LINEAR) low = base_d[BURST_W-1:0] + cnt_d;
    else                                        low = base_d[BURST_W-1:0] ^ cnt_d;
    beat_addr_o = {base_d[ADDR_W-1:BURST_W], low};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en_i) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  // R5: suspended beat keeps the burst position
  p_suspend_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i && !adv_i) |=> $stable(cnt_q) && $stable(base_q));
endmodule

// File: rtl/sram_wr_decode.sv
module sram_wr_decode #(
  parameter int LANES = 4
) (
  input  logic             beat_i,
  input  logic             block_i,
  input  logic             gw_ni,
  input  logic             bwe_ni,
  input  logic [LANES-1:0] bw_ni,
  output logic [LANES-1:0] lane_we_o
);
  logic [LANES-1:0] strobe;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign strobe[g] = !gw_ni || (!bwe_ni && !bw_ni[g]);
  end

  assign lane_we_o = (beat_i && !block_i) ? strobe : '0;
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic [LANES-1:0]        we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANES*LANE_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i) begin
      if (we_i[g]) mem_q[addr_i][g*LANE_W +: LANE_W] <= wdata_i[g*LANE_W +: LANE_W];
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl #(
  parameter int ADDR_W  = 8,
  parameter int LANES   = 4,
  parameter int LANE_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sleep_i,
  input  logic                    ce_ni,
  input  logic                    cs0_i,
  input  logic                    cs1_ni,
  input  logic                    adsp_ni,
  input  logic                    adsc_ni,
  input  logic                    adv_ni,
  input  logic                    gw_ni,
  input  logic                    bwe_ni,
  input  logic [LANES-1:0]        bw_ni,
  input  logic                    linear_i,
  input  logic                    oe_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rdata_oe_o
);
  localparam int DATA_W = LANES * LANE_W;

  logic run, sel, start_p, start, beat, wr_now, rd_beat;
  logic active_q, rvalid_q, hold_q, dselp_q;
  logic [ADDR_W-1:0] beat_addr;
  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] mem_rd, rdata_q;

  assign run     = !sleep_i;
  assign sel     = !ce_ni && cs0_i && !cs1_ni;
  assign start_p = !adsp_ni && !ce_ni;     // processor strobe gated by enable
  assign start   = start_p || !adsc_ni;
  assign beat    = start ? sel : active_q;

  burst_addr_seq #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (run),
    .load_i     (start),
    .adv_i      (active_q && !adv_ni),
    .linear_i   (linear_i),
    .addr_i     (addr_i),
    .beat_addr_o(beat_addr)
  );

  sram_wr_decode #(.LANES(LANES)) u_dec (
    .beat_i   (beat && run),
    .block_i  (start_p),
    .gw_ni    (gw_ni),
    .bwe_ni   (bwe_ni),
    .bw_ni    (bw_ni),
    .lane_we_o(lane_we)
  );

  sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk_i  (clk_i),
    .we_i   (lane_we),
    .addr_i (beat_addr),
    .wdata_i(wdata_i),
    .rdata_o(mem_rd)
  );

  assign wr_now  = |lane_we;
  assign rd_beat = beat && !wr_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rvalid_q <= 1'b0;
      hold_q   <= 1'b0;
      dselp_q  <= 1'b0;
      rdata_q  <= '0;
    end else if (run) begin
      active_q <= beat;
      rvalid_q <= rd_beat;
      hold_q   <= start && sel && dselp_q;   // bank switch turnaround
      if (start)   dselp_q <= !sel;
      if (rd_beat) rdata_q <= mem_rd;
    end
  end

  assign rdata_o    = rdata_q;
  assign rdata_oe_o = rvalid_q && !hold_q && !oe_ni && !wr_now;

  p_deselect_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && start && !sel) |=> !rdata_oe_o);

  p_read_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && rd_beat && !(start && sel && dselp_q)) |=> (oe_ni || wr_now || rdata_oe_o));

  p_global_all_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && beat && !start_p && !gw_ni) |-> (&lane_we));

  p_adsp_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adsp_ni && !ce_ni) |-> !wr_now);

  p_sleep_frozen_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> $stable(rdata_o));
endmodule

// File: tb/burst_sram_ctrl_tb_top.sv
`timescale 1ns/1ps
module burst_sram_ctrl_tb_top;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic sleep = 0, ce = 0, cs0 = 1, cs1 = 0, adsp = 1, adsc = 1, adv = 1;
  logic gw = 1, bwe = 1, linear = 1, oe = 0;
  logic [3:0]  bw = 4'hF;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_o;
  logic        rdata_oe_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [31:0] m_mem [256];
  int m_base = 0, m_cnt = 0;
  bit m_active = 0, m_rv = 0, m_hold = 0, m_dselp = 0;
  logic [31:0] m_rdata = '0;

  always #4 clk_i = ~clk_i;

  burst_sram_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sleep_i(sleep), .ce_ni(ce), .cs0_i(cs0),
    .cs1_ni(cs1), .adsp_ni(adsp), .adsc_ni(adsc), .adv_ni(adv), .gw_ni(gw),
    .bwe_ni(bwe), .bw_ni(bw), .linear_i(linear), .oe_ni(oe), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o)
  );

  task automatic chk1(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: rdata_oe_o=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: rdata_o=%h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // One beat: inputs already set after a falling edge; predict, compare, commit.
  task automatic step(input string tag);
    bit sp, st, sl, bt, eoe;
    int cn, bn, lo, a;
    logic [3:0] be;
    #1;
    sp = !adsp && !ce;
    st = sp || !adsc;
    sl = !ce && cs0 && !cs1;
    bt = st ? sl : m_active;
    cn = st ? 0 : ((m_active && !adv) ? (m_cnt + 1) % 4 : m_cnt);
    bn = st ? int'(addr) : m_base;
    lo = linear ? ((bn + cn) & 3) : ((bn ^ cn) & 3);
    a  = (bn & 252) | lo;
    be = 4'h0;
    if (bt && !sp && !sleep) begin
      if (!gw)       be = 4'hF;
      else if (!bwe) be = ~bw;
    end
    eoe = m_rv && !m_hold && !oe && (be == 4'h0);
    chk1(tag, rdata_oe_o, eoe);
    if (eoe) chk32(tag, rdata_o, m_rdata);
    @(posedge clk_i);
    if (!sleep) begin
      for (int l = 0; l < 4; l++) if (be[l]) m_mem[a][l*8 +: 8] = wdata[l*8 +: 8];
      m_hold   = st && sl && m_dselp;
      if (st) m_dselp = !sl;
      m_active = bt;
      m_base   = bn;
      m_cnt    = cn;
      m_rv     = bt && (be == 4'h0);
      if (m_rv) m_rdata = m_mem[a];
    end
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk_i);
    chk1("R13", rdata_oe_o, 1'b0);
    chk32("R13", rdata_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    step("R13");

    // linear burst of global writes at 0x10..0x13
    adsc = 0; addr = 8'h10; gw = 0; wdata = 32'hA0A0_0000; step("R6");
    adsc = 1; adv = 0;
    for (int i = 1; i < 4; i++) begin wdata = 32'hA0A0_0000 + i; step("R6"); end
    adv = 1; gw = 1; step("R9");

    // linear read from 0x12: 12,13,10,11 then wrap
    adsp = 0; addr = 8'h12; step("R2");
    chk32("R2", rdata_o, 32'hA0A0_0002);
    adsp = 1; adv = 0;
    step("R3"); chk32("R3", rdata_o, 32'hA0A0_0003);
    step("R3"); chk32("R3", rdata_o, 32'hA0A0_0000);
    step("R3"); chk32("R3", rdata_o, 32'hA0A0_0001);
    step("R3"); chk32("R3", rdata_o, 32'hA0A0_0002);
    adv = 1;
    step("R5"); chk32("R5", rdata_o, 32'hA0A0_0002);
    step("R5");

    // interleaved read from 0x11: 11,10,13,12
    linear = 0; adsp = 0; addr = 8'h11; step("R4");
    adsp = 1; adv = 0;
    step("R4"); chk32("R4", rdata_o, 32'hA0A0_0000);
    step("R4"); chk32("R4", rdata_o, 32'hA0A0_0003);
    step("R4"); chk32("R4", rdata_o, 32'hA0A0_0002);
    adv = 1; linear = 1;

    // lane writes
    adsc = 0; addr = 8'h10; bwe = 0; bw = 4'b1010; wdata = 32'h1122_3344; step("R7");
    addr = 8'h11; bwe = 1; bw = 4'h0; wdata = 32'hFFFF_FFFF; step("R7");
    addr = 8'h10; bw = 4'hF; step("R7");
    chk32("R7", rdata_o, 32'hA022_0044);
    addr = 8'h11; step("R7");
    chk32("R7", rdata_o, 32'hA0A0_0001);
    adsc = 1;

    // processor strobe blocks writes; ignored while ce high
    adsp = 0; addr = 8'h12; gw = 0; wdata = 32'hDEAD_BEEF; step("R8");
    chk32("R8", rdata_o, 32'hA0A0_0002);
    ce = 1; addr = 8'h30; wdata = 32'h5555_5555; step("R8");
    adsp = 1; ce = 0; gw = 1; adsc = 0; addr = 8'h12; step("R8");
    chk32("R8", rdata_o, 32'h5555_5555);
    adsc = 1; step("R8");

    // write drive-off and read-after-write
    adsc = 0; addr = 8'h20; gw = 0; wdata = 32'hC0FF_EE00; step("R9");
    gw = 1; step("R9");
    chk32("R9", rdata_o, 32'hC0FF_EE00);
    adsc = 1; step("R9");

    // deselect, then bank switch hold
    ce = 1; adsc = 0; step("R1");
    adsc = 1; step("R1");
    chk1("R1", rdata_oe_o, 1'b0);
    step("R1");
    ce = 0; adsc = 0; addr = 8'h20; step("R10");
    adsc = 1; step("R10");
    step("R10");
    #1 chk1("R10", rdata_oe_o, 1'b1);
    @(negedge clk_i);

    oe = 1; step("R11");
    chk1("R11", rdata_oe_o, 1'b0);
    oe = 0;

    // sleep: nothing may change
    sleep = 1; adsc = 0; addr = 8'h20; gw = 0; wdata = 32'h0; step("R12");
    step("R12");
    chk32("R12", rdata_o, 32'hC0FF_EE00);
    sleep = 0; gw = 1; ce = 1; step("R12");
    ce = 0; step("R12");
    adsc = 1; step("R12");
    step("R12");
    chk32("R12", rdata_o, 32'hC0FF_EE00);

    finish_run();
  end
endmodule